// File: doc/BRIEF.md
# Scanned Keypad Encoder with Key FIFO

This block scans a matrix of front-panel switches. A free-running 4-bit binary column number leaves the block on `scan_out`, and an external decoder turns it into column strobes. Eight return lines come back into the block. A switch that stays closed long enough is accepted. The block then encodes it from the column number and the return-line index and stores the code in an eight-entry FIFO.

A host reads the codes over a small parallel register port. The port has a chip select, one address bit, read and write strobes, and byte-wide data. Address 1 holds commands and status, and address 0 holds key data. The column stepping rate comes from a reference strobe, which a prescaler divides by a divisor that the host can program.

All bus inputs are sampled on `clk`. A bus access lasts for as many clock cycles as the host holds its strobe low.

Top module: `kbd_scan_encoder`

## Requirements
- R1: While `rst` is high and after it falls, `scan_out` is 0, the FIFO is empty, the overrun flag is clear and the step divisor is 10.
- R2: `scan_out` steps by one (modulo 16) after every D high cycles of `ref_en`, where D is the step divisor. While `ref_en` is low, `scan_out` does not move.
- R3: A write with `a0`=1 and a byte of the form 3'b001 followed by a 5-bit field d sets the divisor to d (0 counts as 1). The write takes effect when the write strobe ends. Writes with `a0`=0, and command bytes with any other top three bits, have no effect.
- R4: Return lines are active high. They are sampled once per column step, and only while `scan_out[3]` is 0. Columns 8 to 15 never produce keys.
- R5: A closure is accepted only after it is seen in two consecutive full scan cycles. A shorter closure produces nothing. A held key gives one code, and the same key gives a new code after it is released and pressed again.
- R6: A key code is {2'b00, column[2:0], return_index[2:0]}.
- R7: At most one new key is accepted per full scan cycle. Among keys in the same column, the lowest return index goes first, and the other keys follow in later scan cycles.
- R8: A data read (`a0`=0) returns the oldest stored code and removes it when the read strobe ends. The FIFO keeps codes in arrival order. A read of an empty FIFO returns 8'h00 and changes nothing.
- R9: A status read (`a0`=1) returns {overrun, 3'b000, count[3:0]}, where count is the number of stored codes (0 to 8).
- R10: A key accepted while the FIFO holds 8 codes is dropped and sets the overrun flag. The flag clears when a status read strobe ends.
- R11: `dout_oe` is high exactly while `cs_n` and `rd_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | Reference strobe counted by the prescaler |
| ret | input | 8 | Return lines, high = switch closed |
| scan_out | output | 4 | Binary column number for the external decoder |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | 1 = command/status, 0 = key data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Read data drive enable (low = released) |

## Verification
The hardest case to reach is the overrun. It needs nine separate keys, each held through two full scan cycles. Before it, the cases most easily lost are the short closure and two keys shared within one column.

The bench models the switch matrix from `scan_out`, so every closure reaches the return lines only while its own column is selected. It first programs a small divisor, which keeps each scan cycle short. It then presses keys in sequence and expects each code in a scoreboard queue. Before draining the FIFO it checks the status byte twice: the first read must show the overrun flag and the second must show it cleared.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int KEY_W  = 8;
    localparam int RET_N  = 8;
    localparam int COL_W  = 3;
    localparam int SCAN_W = 4;
    localparam int DIV_W  = 5;
    localparam int NKEYS  = (1 << COL_W) * RET_N;
    localparam logic [2:0] CMD_DIV_OP = 3'b001;

    typedef struct packed {
        logic       overrun;
        logic [2:0] zero;
        logic [3:0] count;
    } status_t;
endpackage

// File: rtl/kbd_prescaler.sv
module kbd_prescaler #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = (div == '0) ? '0 : div - 1'b1;
        tick = 1'b0;
        if (ref_en) begin
            if (st_q.cnt >= lim) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
        tick |-> ref_en);                                   // R2
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        tick |=> st_q.cnt == '0);                           // R2
endmodule

// File: rtl/kbd_scan_debounce.sv
module kbd_scan_debounce
    import kbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [RET_N-1:0]  ret,
    output logic [SCAN_W-1:0] scan,
    output logic              push,
    output logic [KEY_W-1:0]  code
);
    typedef struct packed {
        logic [SCAN_W-1:0] scan;
        logic [NKEYS-1:0]  seen;
        logic [NKEYS-1:0]  done;
        logic              got;
        logic              push;
        logic [KEY_W-1:0]  code;
    } st_t;

    st_t st_d, st_q;
    logic [COL_W-1:0] col;
    logic             found;
    int               idx;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        col       = st_q.scan[COL_W-1:0];
        found     = 1'b0;
        idx       = 0;
        if (tick) begin
            if (!st_q.scan[SCAN_W-1]) begin
                for (int r = 0; r < RET_N; r++) begin
                    idx = int'(col) * RET_N + r;
                    if (ret[r] && st_q.seen[idx] && !st_q.done[idx]
                        && !st_q.got && !found) begin
                        found          = 1'b1;
                        st_d.done[idx] = 1'b1;
                        st_d.push      = 1'b1;
                        st_d.code      = {2'b00, col, 3'(r)};
                    end
                    if (!ret[r]) st_d.done[idx] = 1'b0;
                    st_d.seen[idx] = ret[r];
                end
            end
            st_d.scan = st_q.scan + 1'b1;
            if (st_q.scan == '1) st_d.got = 1'b0;
            else if (found)      st_d.got = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign scan = st_q.scan;
    assign push = st_q.push;
    assign code = st_q.code;

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> scan == $past(scan) + 1'b1);               // R2
    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(scan));                           // R2
    AST_PUSH_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(tick));                              // R4
    AST_CODE_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        push |-> code[KEY_W-1:KEY_W-2] == 2'b00);           // R6
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push,
    input  logic [W-1:0]           wdata,
    input  logic                   pop,
    output logic [W-1:0]           head,
    output logic [$clog2(DEPTH):0] count,
    output logic                   drop
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];
    logic         full, empty, do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        full    = (st_q.cnt == (AW+1)'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        drop    = push && !do_push;
        if (do_push) begin
            mem_d[st_q.wp] = wdata;
            st_d.wp        = st_q.wp + 1'b1;
        end
        if (do_pop) st_d.rp = st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        head     = empty ? '0 : mem_q[st_q.rp];
        count    = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
        mem_q <= mem_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));                           // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (count == (AW+1)'(DEPTH) && push && !pop) |=> count == (AW+1)'(DEPTH)); // R10
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && pop && !push) |=> count == '0);     // R8
endmodule

// File: rtl/kbd_scan_encoder.sv
module kbd_scan_encoder
    import kbd_pkg::*;
#(
    parameter int          DEPTH   = 8,
    parameter logic [4:0]  DIV_RST = 5'd10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic [RET_N-1:0]  ret,
    output logic [SCAN_W-1:0] scan_out,
    input  logic              cs_n,
    input  logic              a0,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [KEY_W-1:0]  din,
    output logic [KEY_W-1:0]  dout,
    output logic              dout_oe
);
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             wr_act;
        logic             wr_a0;
        logic [KEY_W-1:0] wr_byte;
        logic             rd_act;
        logic             rd_a0;
        logic             ovr;
    } bus_t;

    bus_t bus_d, bus_q;
    logic             tick, push, pop, drop;
    logic [KEY_W-1:0] code, head;
    logic [CW-1:0]    count;
    logic             wr_now, rd_now, wr_end, rd_end;
    status_t          stat;

    kbd_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .ref_en(ref_en), .div(bus_q.div), .tick(tick)
    );

    kbd_scan_debounce u_scan (
        .clk(clk), .rst(rst), .tick(tick), .ret(ret),
        .scan(scan_out), .push(push), .code(code)
    );

    kbd_fifo #(.W(KEY_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(code), .pop(pop),
        .head(head), .count(count), .drop(drop)
    );

    always_comb begin
        bus_d  = bus_q;
        wr_now = !cs_n && !wr_n;
        rd_now = !cs_n && !rd_n;
        wr_end = bus_q.wr_act && !wr_now;
        rd_end = bus_q.rd_act && !rd_now;
        pop    = rd_end && !bus_q.rd_a0;
        bus_d.wr_act = wr_now;
        bus_d.rd_act = rd_now;
        if (wr_now) begin
            bus_d.wr_a0   = a0;
            bus_d.wr_byte = din;
        end
        if (rd_now) bus_d.rd_a0 = a0;
        if (wr_end && bus_q.wr_a0 && bus_q.wr_byte[7:5] == CMD_DIV_OP)
            bus_d.div = bus_q.wr_byte[DIV_W-1:0];
        if (rd_end && bus_q.rd_a0) bus_d.ovr = 1'b0;
        if (drop) bus_d.ovr = 1'b1;

        stat.overrun = bus_q.ovr;
        stat.zero    = '0;
        stat.count   = 4'(count);
        dout_oe      = rd_now;
        dout         = a0 ? KEY_W'(stat) : head;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q     <= '0;
            bus_q.div <= DIV_RST;
        end else begin
            bus_q <= bus_d;
        end
    end

    AST_DIV_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_end |=> $stable(bus_q.div));                    // R3
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (bus_q.ovr && !(rd_end && bus_q.rd_a0)) |=> bus_q.ovr); // R10
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        drop |=> bus_q.ovr);                                // R10
endmodule

// File: tb/kbd_scan_encoder_bench.sv
module kbd_scan_encoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b1;
    logic [7:0] ret;
    logic [3:0] scan_out;
    logic       cs_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] keys [8];

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    kbd_scan_encoder u_kbd_scan_encoder (
        .clk(clk), .rst(rst), .ref_en(ref_en), .ret(ret), .scan_out(scan_out),
        .cs_n(cs_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    always_comb ret = scan_out[3] ? 8'h00 : keys[scan_out[2:0]];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic addr, input logic [7:0] b);
        @(negedge clk); cs_n = 0; a0 = addr; din = b; wr_n = 0;
        repeat (2) @(negedge clk);
        wr_n = 1; cs_n = 1;
        cycles(2);
    endtask

    task automatic bus_read(input logic addr, output logic [7:0] b);
        @(negedge clk); cs_n = 0; a0 = addr; rd_n = 0;
        repeat (2) @(negedge clk);
        b = dout;
        rd_n = 1; cs_n = 1;
        cycles(2);
    endtask

    task automatic measure(input string req, input int exp);
        logic [3:0] last;
        int n;
        last = scan_out;
        while (scan_out == last) cycles(1);
        last = scan_out; n = 0;
        while (scan_out == last) begin cycles(1); n++; end
        check(req, n, exp);
    endtask

    // driver: press a key long enough to be accepted, queue the expected code
    task automatic press(input int col, input int row, input bit expect_it);
        keys[col][row] = 1'b1;
        cycles(200);
        keys[col][row] = 1'b0;
        cycles(80);
        if (expect_it) exp_q.push_back({2'b00, 3'(col), 3'(row)});
    endtask

    // monitor: pop every stored code and compare against the scoreboard
    task automatic drain(input string req);
        logic [7:0] b;
        while (exp_q.size() > 0) begin
            bus_read(1'b0, b);
            check(req, b, exp_q.pop_front());
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        logic [3:0] held;
        for (int i = 0; i < 8; i++) keys[i] = 8'h00;
        cycles(3);
        check("R1 scan reset", scan_out, 0);
        check("R11 oe idle", dout_oe, 0);
        @(negedge clk); rst = 0;
        cycles(1);
        check("R1 scan after reset", scan_out, 0);
        bus_read(1'b1, b);
        check("R1 status reset", b, 8'h00);
        measure("R1 R2 default divisor", 10);

        held = scan_out; ref_en = 0; cycles(50);
        check("R2 stall without ref_en", scan_out, held);
        ref_en = 1;

        bus_write(1'b1, 8'h23);
        measure("R3 divisor 3", 3);
        bus_write(1'b0, 8'h25);
        measure("R3 data write ignored", 3);
        bus_write(1'b1, 8'h45);
        measure("R3 other command ignored", 3);
        bus_write(1'b1, 8'h22);
        measure("R3 divisor 2", 2);

        // R11 decode
        @(negedge clk); cs_n = 1; rd_n = 0; #1;
        check("R11 oe needs cs", dout_oe, 0);
        cs_n = 0; #1;
        check("R11 oe active", dout_oe, 1);
        rd_n = 1; cs_n = 1; #1;
        cycles(1);
        bus_write(1'b0, 8'h00);

        // R8 empty read
        bus_read(1'b0, b);
        check("R8 empty read", b, 8'h00);
        bus_read(1'b1, b);
        check("R8 empty stays empty", b, 8'h00);

        // R5 short closure
        while (scan_out != 4'd2) cycles(1);
        keys[5][3] = 1; cycles(8); keys[5][3] = 0;
        cycles(120);
        bus_read(1'b1, b);
        check("R5 short closure ignored", b, 8'h00);

        // R6 R4 single key one code
        press(5, 3, 1);
        bus_read(1'b1, b);
        check("R4 R5 one code per hold", b, 8'h01);
        drain("R6 code format");

        // R7 two keys in one column
        keys[2][6] = 1; keys[2][1] = 1;
        cycles(250);
        keys[2][6] = 0; keys[2][1] = 0;
        cycles(80);
        exp_q.push_back(8'h11); exp_q.push_back(8'h16);
        bus_read(1'b1, b);
        check("R7 both keys stored", b, 8'h02);
        drain("R7 lowest index first");

        // R5 re-press gives new code
        press(0, 7, 1);
        press(0, 7, 1);
        drain("R5 re-press");

        // R10 overrun with nine keys
        for (int k = 0; k < 9; k++) press(k % 8, (k * 3) % 8, k < 8);
        bus_read(1'b1, b);
        check("R9 R10 status full with overrun", b, 8'h88);
        bus_read(1'b1, b);
        check("R10 overrun cleared", b, 8'h08);
        drain("R8 R10 order after overrun");
        bus_read(1'b1, b);
        check("R9 status after drain", b, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule